// File: doc/BRIEF.md
# Byte-wide SPI Master/Slave Port

A serial peripheral port that exchanges one data word at a time with an external device over SCK, MOSI, MISO and an active-low select. An 8-bit control register picks interrupt enable, port enable, shift order, master or slave role, clock idle level, sampling phase and a two-bit rate code. A separate double-speed input widens the rate code to three bits.

As a master, the port divides the system clock to generate SCK. A data write starts a transfer that shifts the word out on MOSI while shifting a word in from MISO. As a slave, it follows an external SCK and select, both brought into the system clock domain. A completion flag is set at the end of each word. The flag, the interrupt enable bit and a global enable input together raise an interrupt request. While in master mode, a low level on a select pin that is configured as an input is treated as a mode fault. The fault returns the port to slave mode and sets the flag.

Top module: `spi_port`

## Requirements
- R1: After reset, ctrl_q is 0x00, done_flag, irq, sck_oe, mosi_oe and miso_oe are 0, and sck_out is 0.
- R2: While the enable bit (ctrl bit 6) is 0, a data write starts no transfer: sck_out stays at the polarity level and done_flag stays 0.
- R3: With the order bit (ctrl bit 5) at 0 the most significant bit goes out first. With it at 1 the least significant bit goes out first. A master presents the first bit on mosi_out in the cycle after the write is taken. Two ports with opposite order settings receive each other's words bit-reversed.
- R4: With polarity bit (ctrl bit 3) at 0, SCK idles low. With it at 1, SCK idles high. A master's sck_out is back at the idle level when its transfer ends.
- R5: With phase bit (ctrl bit 2) at 0, data is sampled on the leading SCK edge and changed on the trailing edge. With it at 1, data changes on the leading edge and is sampled on the trailing edge. A master and a slave in the same mode exchange words correctly in all four modes.
- R6: The master divide ratio is chosen by the code {dbl_speed, ctrl bit 1, ctrl bit 0}: 000 gives 4, 001 gives 16, 010 gives 64, 011 gives 128, 100 gives 2, 101 gives 8, 110 gives 32, 111 gives 64. done_flag rises exactly 8 x ratio cycles after the clock edge that takes the data write.
- R7: The rate bits have no effect on a slave.
- R8: If ss_is_input is 1 and the synchronized ss_n_in is low while the master bit (ctrl bit 4) is 1 and the port is enabled, the hardware clears the master bit and sets done_flag. The master bit stays 0 until it is written to 1 again.
- R9: irq is 1 exactly when the interrupt enable bit (ctrl bit 7), done_flag and gie are all 1.
- R10: done_flag is set when a word completes and is cleared by a pulse on flag_clr.
- R11: In slave mode with select high, SCK is ignored: no bit is taken, rx_data and done_flag do not change, and miso_oe is 0. Raising select clears the slave bit counter, so a word cut short is discarded and the next word arrives intact.
- R12: A data write to a master that is already busy is ignored. The word in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register contents |
| dbl_speed | input | 1 | Double-speed bit of the rate code |
| data_we | input | 1 | Data write strobe (starts master transfer / loads slave word) |
| data_wdata | input | DW | Word to transmit |
| rx_data | output | DW | Last word received |
| flag_clr | input | 1 | Clears the completion flag |
| gie | input | 1 | Global interrupt enable |
| done_flag | output | 1 | Transfer-complete / mode-fault flag |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Drive enable for SCK |
| mosi_in | input | 1 | Serial data in as slave |
| mosi_out | output | 1 | Serial data out as master |
| mosi_oe | output | 1 | Drive enable for MOSI |
| miso_in | input | 1 | Serial data in as master |
| miso_out | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | Drive enable for MISO (slave selected) |
| ss_n_in | input | 1 | Active-low select pin level |
| ss_is_input | input | 1 | Select pin is configured as an input |

## Verification
The bench builds two copies with DW = 8 and SYNC_STAGES = 2, one acting as master and one as slave, wired back to back. Each word is therefore checked against an independent receiver rather than a loopback. With an 8-bit word and two synchronizer stages, every combination of polarity, phase and order can be swept at two rates, each with several data patterns. All eight rate codes are timed to the exact cycle. The small synchronizer depth keeps the slave's response well inside half an SCK period at ratios of 16 and above. The bench also covers mismatched order settings, a select raised in the middle of a word, and the fault, enable and interrupt gating cases.

// File: rtl/spi_pkg.sv
package spi_pkg;
   localparam int CTRL_W = 8;
   // control register bit positions
   localparam int B_IE  = 7;
   localparam int B_EN  = 6;
   localparam int B_ORD = 5;
   localparam int B_MS  = 4;
   localparam int B_POL = 3;
   localparam int B_PHA = 2;

   // terminal count of the half-period counter for a 3-bit rate code
   function automatic logic [5:0] half_term(input logic [2:0] code);
      logic [7:0] ratio;
      case (code[1:0])
         2'd0:    ratio = 8'd4;
         2'd1:    ratio = 8'd16;
         2'd2:    ratio = 8'd64;
         default: ratio = 8'd128;
      endcase
      ratio = ratio >> code[2];
      return 6'((ratio >> 1) - 8'd1);
   endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [W-1:0] init,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 1 && STAGES <= 4) else $error("spi_sync: STAGES out of range");

   if (STAGES == 1) begin : g_single
      logic [W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) r_q <= init;
         else        r_q <= d;
      assign q = r_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) stg <= {STAGES{init}};
         else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
   parameter int DW     = 8,
   parameter int HALF_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       abort,
   input  logic       cpol,
   input  logic [2:0] rate,
   output logic       sck,
   output logic       busy,
   output logic       lead,
   output logic       trail,
   output logic       last
);
   localparam int EDGES = 2 * DW;
   localparam int EW    = $clog2(EDGES);

   initial assert (HALF_W >= 6) else $error("spi_sck_gen: HALF_W too small for slowest rate");

   logic [HALF_W-1:0] cnt_q, term_q;
   logic [EW-1:0]     ecnt_q;
   logic              sck_q, cpol_q, busy_q, tick;

   assign tick  = busy_q && (cnt_q == term_q);
   assign lead  = tick && !ecnt_q[0];
   assign trail = tick &&  ecnt_q[0];
   assign last  = tick && (ecnt_q == EW'(EDGES - 1));
   assign busy  = busy_q;
   assign sck   = busy_q ? sck_q : cpol;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         term_q <= '0;
         ecnt_q <= '0;
         sck_q  <= 1'b0;
         cpol_q <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         ecnt_q <= '0;
         term_q <= HALF_W'(spi_pkg::half_term(rate));
         sck_q  <= cpol;
         cpol_q <= cpol;
      end else if (busy_q) begin
         if (tick) begin
            cnt_q  <= '0;
            sck_q  <= ~sck_q;
            ecnt_q <= ecnt_q + 1'b1;
            if (last) busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

   AST_SCK_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !abort) |=> (sck_q == cpol_q));   // R4
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && term_q != '0 && !last) |=> !tick); // R6
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          dord,
   input  logic          sample,
   input  logic          din,
   input  logic          setup,
   input  logic          follow,
   input  logic          clr,
   input  logic          capture,
   output logic          dout,
   output logic [DW-1:0] rx_buf,
   output logic          byte_done
);
   localparam int CW = $clog2(DW);

   initial assert (DW >= 2) else $error("spi_shift: DW must be at least 2");

   logic [DW-1:0] sr, shifted;
   logic [CW-1:0] cnt;
   logic          out_bit, mo_r;

   assign out_bit   = dord ? sr[0] : sr[DW-1];
   assign shifted   = dord ? {din, sr[DW-1:1]} : {sr[DW-2:0], din};
   assign byte_done = sample && (cnt == CW'(DW - 1));
   assign dout      = mo_r;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sr     <= '0;
         cnt    <= '0;
         mo_r   <= 1'b0;
         rx_buf <= '0;
      end else begin
         if (load)        sr <= load_data;
         else if (sample) sr <= shifted;

         if (clr)         cnt <= '0;
         else if (sample) cnt <= byte_done ? '0 : cnt + 1'b1;

         if (load)                 mo_r <= dord ? load_data[0] : load_data[DW-1];
         else if (setup || follow) mo_r <= out_bit;

         if (capture) rx_buf <= sample ? shifted : sr;
      end
endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HALF_W      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic [7:0]    ctrl_wdata,
   output logic [7:0]    ctrl_q,
   input  logic          dbl_speed,
   input  logic          data_we,
   input  logic [DW-1:0] data_wdata,
   output logic [DW-1:0] rx_data,
   input  logic          flag_clr,
   input  logic          gie,
   output logic          done_flag,
   output logic          irq,
   input  logic          sck_in,
   output logic          sck_out,
   output logic          sck_oe,
   input  logic          mosi_in,
   output logic          mosi_out,
   output logic          mosi_oe,
   input  logic          miso_in,
   output logic          miso_out,
   output logic          miso_oe,
   input  logic          ss_n_in,
   input  logic          ss_is_input
);
   logic [CTRL_W-1:0] ctrl_r;
   logic              flag_r;
   logic [2:0]        raw_in, sync_out;
   logic              s_sck, s_mosi, s_ss_n, sck_d;
   logic              en, mst, cpol, cpha, dord;
   logic              rise, fall, lead_s, trail_s, slave_act;
   logic              s_sample, s_setup, s_load, s_done;
   logic              fault, m_start, m_abort, m_busy;
   logic              m_lead, m_trail, m_last, m_sck;
   logic              sh_sample, sh_setup, sh_din, sh_clr, sh_capture, sh_dout;
   logic              set_flag;

   assign en   = ctrl_r[B_EN];
   assign mst  = ctrl_r[B_MS];
   assign cpol = ctrl_r[B_POL];
   assign cpha = ctrl_r[B_PHA];
   assign dord = ctrl_r[B_ORD];

   // pin synchronization for the slave side and the select pin
   assign raw_in = {sck_in, mosi_in, ss_n_in};
   spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .init (3'b001),
      .q    (sync_out)
   );
   assign {s_sck, s_mosi, s_ss_n} = sync_out;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= s_sck;

   assign rise      = s_sck && !sck_d;
   assign fall      = !s_sck && sck_d;
   assign lead_s    = cpol ? fall : rise;
   assign trail_s   = cpol ? rise : fall;
   assign slave_act = en && !mst && !s_ss_n;
   assign s_sample  = slave_act && (cpha ? trail_s : lead_s);
   assign s_setup   = slave_act && (cpha ? lead_s : trail_s);
   assign s_load    = data_we && en && !mst && s_ss_n;

   // master control
   assign fault   = en && mst && ss_is_input && !s_ss_n;
   assign m_start = data_we && en && mst && !m_busy && !fault;
   assign m_abort = m_busy && (fault || !en || !mst);

   spi_sck_gen #(.DW(DW), .HALF_W(HALF_W)) u_sck (
      .clk  (clk),
      .rst_n(rst_n),
      .start(m_start),
      .abort(m_abort),
      .cpol (cpol),
      .rate ({dbl_speed, ctrl_r[1:0]}),
      .sck  (m_sck),
      .busy (m_busy),
      .lead (m_lead),
      .trail(m_trail),
      .last (m_last)
   );

   assign sh_sample  = mst ? (cpha ? m_trail : m_lead) : s_sample;
   assign sh_setup   = mst ? (cpha ? m_lead : m_trail) : s_setup;
   assign sh_din     = mst ? miso_in : s_mosi;
   assign sh_clr     = mst ? m_start : (s_ss_n || !en);
   assign sh_capture = mst ? (m_last && !m_abort) : s_done;

   spi_shift #(.DW(DW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (m_start || s_load),
      .load_data(data_wdata),
      .dord     (dord),
      .sample   (sh_sample),
      .din      (sh_din),
      .setup    (sh_setup),
      .follow   (!mst && s_ss_n),
      .clr      (sh_clr),
      .capture  (sh_capture),
      .dout     (sh_dout),
      .rx_buf   (rx_data),
      .byte_done(s_done)
   );

   // control register and completion flag
   assign set_flag = sh_capture || fault;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ctrl_r <= '0;
         flag_r <= 1'b0;
      end else begin
         if (ctrl_we) ctrl_r <= ctrl_wdata;
         if (fault)   ctrl_r[B_MS] <= 1'b0;
         if (set_flag)      flag_r <= 1'b1;
         else if (flag_clr) flag_r <= 1'b0;
      end

   assign ctrl_q    = ctrl_r;
   assign done_flag = flag_r;
   assign irq       = ctrl_r[B_IE] && flag_r && gie;
   assign sck_out   = m_sck;
   assign sck_oe    = en && mst;
   assign mosi_out  = sh_dout;
   assign mosi_oe   = en && mst;
   assign miso_out  = sh_dout;
   assign miso_oe   = slave_act;

   AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!ctrl_q[B_MS] && done_flag));             // R8
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_r[B_EN] |=> !m_busy);                           // R2
   AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !set_flag) |=> !irq);                    // R10
   AST_SLAVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_r[B_MS] && s_ss_n) |=> $stable(rx_data));      // R11
endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // master side
   logic       m_cwe = 0, m_dwe = 0, m_clr = 0, m_dbl = 0, m_ss = 1, m_ss_in = 0;
   logic [7:0] m_cwd = 0, m_dwd = 0, m_cq, m_rx;
   logic       m_flag, m_irq, m_sck, m_sck_oe, m_mosi, m_mosi_oe, m_miso_o, m_miso_oe;
   // slave side
   logic       s_cwe = 0, s_dwe = 0, s_clr = 0, s_ss = 1;
   logic [7:0] s_cwd = 0, s_dwd = 0, s_cq, s_rx;
   logic       s_flag, s_irq, s_sck_o, s_sck_oe, s_mosi_o, s_mosi_oe, s_miso, s_miso_oe;
   logic       gie = 0;

   int n_vec = 0, n_bad = 0, cyc = 0;

   spi_port #(.DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_we(m_cwe), .ctrl_wdata(m_cwd), .ctrl_q(m_cq),
      .dbl_speed(m_dbl), .data_we(m_dwe), .data_wdata(m_dwd), .rx_data(m_rx),
      .flag_clr(m_clr), .gie(gie), .done_flag(m_flag), .irq(m_irq),
      .sck_in(1'b0), .sck_out(m_sck), .sck_oe(m_sck_oe),
      .mosi_in(1'b0), .mosi_out(m_mosi), .mosi_oe(m_mosi_oe),
      .miso_in(s_miso), .miso_out(m_miso_o), .miso_oe(m_miso_oe),
      .ss_n_in(m_ss), .ss_is_input(m_ss_in));

   spi_port #(.DW(DW)) slave_i (
      .clk(clk), .rst_n(rst_n), .ctrl_we(s_cwe), .ctrl_wdata(s_cwd), .ctrl_q(s_cq),
      .dbl_speed(1'b0), .data_we(s_dwe), .data_wdata(s_dwd), .rx_data(s_rx),
      .flag_clr(s_clr), .gie(gie), .done_flag(s_flag), .irq(s_irq),
      .sck_in(m_sck), .sck_out(s_sck_o), .sck_oe(s_sck_oe),
      .mosi_in(m_mosi), .mosi_out(s_mosi_o), .mosi_oe(s_mosi_oe),
      .miso_in(1'b0), .miso_out(s_miso), .miso_oe(s_miso_oe),
      .ss_n_in(s_ss), .ss_is_input(1'b0));

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog R6 actual=%0d cycles expected<%0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   task automatic check_eq(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(input logic ie, en, ord, ms, pol, pha, input logic [1:0] r);
      return {ie, en, ord, ms, pol, pha, r};
   endfunction

   function automatic logic [7:0] rev(input logic [7:0] b);
      logic [7:0] o;
      for (int i = 0; i < 8; i++) o[i] = b[7-i];
      return o;
   endfunction

   function automatic int ratio_of(input logic [2:0] code);
      int base;
      base = (code[1:0] == 2'd3) ? 128 : (4 << (2 * code[1:0]));
      return base >> code[2];
   endfunction

   task automatic wr_m_ctrl(input logic [7:0] v);
      m_cwe = 1; m_cwd = v; @(negedge clk); m_cwe = 0;
   endtask

   task automatic wr_s_ctrl(input logic [7:0] v);
      s_cwe = 1; s_cwd = v; @(negedge clk); s_cwe = 0;
   endtask

   task automatic clr_flags();
      m_clr = 1; s_clr = 1; @(negedge clk); m_clr = 0; s_clr = 0;
   endtask

   // one master-to-slave exchange; data checks optional
   task automatic xfer(input logic pol, pha, mord, sord, input logic [2:0] code,
                       input logic [1:0] srate, input logic [7:0] mb, sb,
                       input bit chk_data, input bit do_intr);
      int n;
      wr_s_ctrl(mk(0, 1, sord, 0, pol, pha, srate));
      wr_m_ctrl(mk(0, 1, mord, 1, pol, pha, code[1:0]));
      m_dbl = code[2];
      s_dwe = 1; s_dwd = sb; @(negedge clk); s_dwe = 0;
      repeat (4) @(negedge clk);
      s_ss = 0;
      repeat (4) @(negedge clk);
      check_eq("R4 idle sck level", m_sck, pol);
      check_eq("R11 miso_oe when selected", s_miso_oe, 1);
      m_dwe = 1; m_dwd = mb;
      @(posedge clk); @(negedge clk);
      m_dwe = 0;
      check_eq("R3 first bit on mosi", m_mosi, mord ? mb[0] : mb[7]);
      n = 0;
      while (!m_flag && n < 4000) begin
         @(posedge clk); n++; @(negedge clk);
         m_dwe = do_intr && (n == 20);
         m_dwd = ~mb;
      end
      m_dwe = 0;
      check_eq("R6 transfer length", n, 8 * ratio_of(code));
      check_eq("R4 sck back at idle", m_sck, pol);
      repeat (8) @(negedge clk);
      if (chk_data) begin
         check_eq(do_intr ? "R12 master rx" : "R5 master rx", m_rx, (mord == sord) ? sb : rev(sb));
         check_eq(do_intr ? "R12 slave rx" : "R3 slave rx", s_rx, (mord == sord) ? mb : rev(mb));
         check_eq("R10 slave flag set", s_flag, 1);
      end
      s_ss = 1;
      clr_flags();
      check_eq("R10 flag cleared", m_flag, 0);
   endtask

   initial begin
      logic [7:0] pats [4];
      int k;
      pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h01; pats[3] = 8'h80;
      repeat (3) @(negedge clk);
      // R1 reset state
      check_eq("R1 ctrl reset", m_cq, 0);
      check_eq("R1 flag reset", m_flag, 0);
      check_eq("R1 irq reset", m_irq, 0);
      check_eq("R1 sck_oe reset", m_sck_oe, 0);
      check_eq("R1 mosi_oe reset", m_mosi_oe, 0);
      check_eq("R1 miso_oe reset", s_miso_oe, 0);
      check_eq("R1 sck reset", m_sck, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 disabled port does nothing
      wr_m_ctrl(mk(0, 0, 0, 1, 1, 0, 2'd0));
      m_dwe = 1; m_dwd = 8'h5A; @(negedge clk); m_dwe = 0;
      repeat (300) @(negedge clk);
      check_eq("R2 flag stays clear", m_flag, 0);
      check_eq("R2 sck stays idle", m_sck, 1);
      check_eq("R2 no sck drive", m_sck_oe, 0);

      // R5 and R3: all modes and orders, several patterns, two rates
      k = 0;
      for (int mode = 0; mode < 8; mode++) begin
         for (int p = 0; p < 4; p++) begin
            xfer(mode[2], mode[1], mode[0], mode[0], (k % 2) ? 3'b010 : 3'b001,
                 2'(k), pats[p], ~pats[(p + 1) % 4], 1, 0);   // R7 slave rate varies
            k++;
         end
      end

      // R3 mismatched order yields reversed words
      xfer(0, 0, 0, 1, 3'b001, 2'd0, 8'hC1, 8'h2E, 1, 0);
      xfer(1, 1, 1, 0, 3'b001, 2'd3, 8'h0F, 8'h71, 1, 0);

      // R7 slave rate bits at both extremes
      xfer(0, 1, 0, 0, 3'b001, 2'd3, 8'h96, 8'h69, 1, 0);
      xfer(0, 1, 0, 0, 3'b001, 2'd0, 8'h96, 8'h69, 1, 0);

      // R6 every rate code timed
      for (int c = 0; c < 8; c++) xfer(0, 0, 0, 0, 3'(c), 2'd0, 8'h55, 8'hAA, 0, 0);

      // R12 write during busy ignored
      xfer(0, 0, 0, 0, 3'b001, 2'd0, 8'hE7, 8'h18, 1, 1);

      // R11 select high: slave ignores sck
      s_ss = 1;
      wr_s_ctrl(mk(0, 1, 0, 0, 0, 0, 2'd0));
      wr_m_ctrl(mk(0, 1, 0, 1, 0, 0, 2'd1));
      m_dbl = 0;
      k = int'(s_rx);
      m_dwe = 1; m_dwd = 8'h3A; @(negedge clk); m_dwe = 0;
      repeat (200) @(negedge clk);
      check_eq("R11 no slave flag while deselected", s_flag, 0);
      check_eq("R11 slave rx unchanged", s_rx, k);
      check_eq("R11 miso_oe off", s_miso_oe, 0);
      clr_flags();
      // R11 partial word discarded, next word intact
      s_dwe = 1; s_dwd = 8'h44; @(negedge clk); s_dwe = 0;
      repeat (4) @(negedge clk);
      s_ss = 0;
      repeat (4) @(negedge clk);
      m_dwe = 1; m_dwd = 8'hB2; @(negedge clk); m_dwe = 0;
      repeat (40) @(negedge clk);
      s_ss = 1;
      repeat (200) @(negedge clk);
      check_eq("R11 cut word gives no flag", s_flag, 0);
      clr_flags();
      xfer(0, 0, 0, 0, 3'b001, 2'd0, 8'hD3, 8'h5C, 1, 0);

      // R8 mode fault
      m_ss_in = 1;
      wr_m_ctrl(mk(0, 1, 0, 1, 0, 0, 2'd0));
      m_ss = 0;
      repeat (5) @(negedge clk);
      check_eq("R8 master bit cleared", m_cq[4], 0);
      check_eq("R8 flag set by fault", m_flag, 1);
      m_ss = 1;
      repeat (5) @(negedge clk);
      check_eq("R8 master stays off", m_cq[4], 0);

      // R9 interrupt gating (flag still set from the fault)
      for (int v = 0; v < 4; v++) begin
         gie = v[1];
         wr_m_ctrl(mk(v[0], 1, 0, 0, 0, 0, 2'd0));
         @(negedge clk);
         check_eq("R9 irq gating", m_irq, v[0] & v[1]);
      end
      clr_flags();
      check_eq("R9 irq drops with flag", m_irq, 0);
      check_eq("R10 flag clear pulse", m_flag, 0);
      // R8 select as output: no fault
      m_ss_in = 0;
      wr_m_ctrl(mk(0, 1, 0, 1, 0, 0, 2'd0));
      m_ss = 0;
      repeat (5) @(negedge clk);
      check_eq("R8 no fault when select is output", m_cq[4], 1);
      m_ss = 1;

      summary();
      $finish;
   end
endmodule